// File: doc/BRIEF.md
# Instruction Cache with Whole-Cache Invalidate

This block sits between a processor's instruction fetch port and a plain word-wide memory port. It holds 16 KB of instructions in a direct-mapped array of 512 lines, each line eight 32-bit words (32 bytes). A fetch that hits is answered one cycle after it is accepted. On a miss the block reads the whole aligned line from memory, one word per handshake, and answers the fetch once the eighth word has arrived.

The cache is read-only and never looks at stores. Memory writes made after a line was filled stay invisible to fetches that hit that line, and a line fill reads memory as it is, with no regard for stores still queued elsewhere. Software that rewrites code must flush the cache. The flush command drops every line at once; no single line can be dropped on its own. Clearing the enable input stops new lines from being allocated, but lines that are already valid keep answering hits until a flush.

Top module: `icache_top`

## Requirements
- R1: On a miss with `enable_i` high, the block issues exactly 8 memory reads at the byte addresses line_base, line_base+4, ... line_base+28, in ascending order, where line_base is the fetch address with bits [4:0] cleared. `mem_addr_o` has bits [1:0] zero and holds steady while `mem_valid_o` is high and `mem_ready_i` is low.
- R2: A filling miss raises `fetch_valid_o` with `fetch_hit_o` low in the cycle after the eighth read's handshake. `fetch_data_o` then carries the memory word at the requested address, and that response always follows a memory handshake in the cycle before.
- R3: A hit raises `fetch_valid_o` and `fetch_hit_o` in the cycle after the fetch is accepted, with the cached word on `fetch_data_o` and no memory request. `fetch_hit_o` is never high without `fetch_valid_o`.
- R4: A hit returns the word as it was when the line was filled, even if memory at that address has been written since.
- R5: A one-cycle pulse on `flush_i` invalidates every line, so the next fetch to any previously cached address misses and returns current memory contents.
- R6: A flush pulse during a line fill lets the fill complete and answer its fetch. It then invalidates every line, including the line just filled.
- R7: On a miss with `enable_i` low, the block makes a single memory read at the requested word and returns it with `fetch_hit_o` low. It allocates nothing, so a repeat fetch misses again.
- R8: With `enable_i` low, lines that are still valid keep answering hits.
- R9: A fetch word address maps to line index = byte address bits [13:5], word offset = bits [4:2] and tag = bits [31:14]. Two addresses with the same index and different tags evict each other.
- R10: After reset, no line is valid and `stall_o`, `fetch_valid_o` and `mem_valid_o` are low. `stall_o` is high from the cycle a miss is detected until the response cycle, and `fetch_valid_o` is never high while `stall_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Allows new lines to be allocated on a miss |
| flush_i | input | 1 | One-cycle pulse that invalidates every line |
| fetch_req_i | input | 1 | Fetch request; accepted when `stall_o` is low |
| fetch_addr_i | input | 30 | Fetch word address (byte address bits [31:2]) |
| fetch_valid_o | output | 1 | Response valid |
| fetch_hit_o | output | 1 | Response was served from the cache |
| fetch_data_o | output | 32 | Instruction word |
| stall_o | output | 1 | Miss outstanding; new fetches are not accepted |
| mem_valid_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_ready_i | input | 1 | Memory accepts the read; data valid in the same cycle |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The hardest case to reach is a flush that arrives while a line fill is partway through. The fill has to finish and deliver its word, and only afterwards can the new line be invalidated along with every other line. The stimulus starts a miss and then pulses the flush two cycles into the random-latency fill. It then fetches the same address again, and that fetch must miss. Stale-hit cases are produced by changing the bench's memory contents behind a cached line. The random phase mixes such writes, flushes and enable toggles over a few lines that share indices.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WADDR_W = 30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_BYPASS,
    ST_DONE
  } ic_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int unsigned NUM_LINES = 512,
  parameter int unsigned TAG_W     = 18,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic             rd_valid_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             flush_all_i
);
  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_mem [NUM_LINES];

  // flush wins over a same-cycle allocation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_all_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_mem[wr_idx_i] <= wr_tag_i;
  end

  assign rd_tag_o   = tag_mem[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int unsigned DEPTH  = 4096,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
  import icache_pkg::*;
#(
  parameter int unsigned LINE_WORDS = 8,
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               flush_i,
  input  logic               fetch_req_i,
  input  logic [WADDR_W-1:0] fetch_addr_i,
  input  logic               hit_i,
  input  logic [WORD_W-1:0]  hit_data_i,
  output logic [WADDR_W-1:0] req_addr_o,
  output logic [OFF_W-1:0]   fill_beat_o,
  output logic               data_we_o,
  output logic               tag_we_o,
  output logic               flush_all_o,
  output logic               fetch_valid_o,
  output logic               fetch_hit_o,
  output logic [WORD_W-1:0]  fetch_data_o,
  output logic               stall_o,
  output logic               mem_valid_o,
  output logic [31:0]        mem_addr_o,
  input  logic               mem_ready_i,
  input  logic [WORD_W-1:0]  mem_rdata_i
);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

  ic_state_e          state_q;
  logic [WADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]   beat_q;
  logic [WORD_W-1:0]  word_q;
  logic               flush_pend_q;
  logic               accept;
  logic               last_beat;

  always_comb begin
    stall_o       = 1'b0;
    fetch_valid_o = 1'b0;
    fetch_hit_o   = 1'b0;
    mem_valid_o   = 1'b0;
    unique case (state_q)
      ST_LOOK: begin
        stall_o       = !hit_i;
        fetch_valid_o = hit_i;
        fetch_hit_o   = hit_i;
      end
      ST_FILL, ST_BYPASS: begin
        stall_o     = 1'b1;
        mem_valid_o = 1'b1;
      end
      ST_DONE: fetch_valid_o = 1'b1;
      default: ;
    endcase
  end

  assign accept       = fetch_req_i && !stall_o;
  assign last_beat    = (state_q == ST_FILL) && mem_ready_i && (beat_q == LAST_BEAT);
  assign data_we_o    = (state_q == ST_FILL) && mem_ready_i;
  assign tag_we_o     = last_beat;
  // a flush seen during a fill is held until the line is complete
  assign flush_all_o  = (state_q == ST_FILL) ? (last_beat && (flush_i || flush_pend_q))
                                             : flush_i;
  assign fetch_data_o = fetch_hit_o ? hit_data_i : word_q;
  assign req_addr_o   = addr_q;
  assign fill_beat_o  = beat_q;
  assign mem_addr_o   = (state_q == ST_FILL) ? {addr_q[WADDR_W-1:OFF_W], beat_q, 2'b00}
                                             : {addr_q, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      beat_q       <= '0;
      word_q       <= '0;
      flush_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            addr_q  <= fetch_addr_i;
            state_q <= ST_LOOK;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_LOOK: begin
          if (hit_i) begin
            if (accept) begin
              addr_q  <= fetch_addr_i;
              state_q <= ST_LOOK;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            beat_q  <= '0;
            state_q <= enable_i ? ST_FILL : ST_BYPASS;
          end
        end
        ST_FILL: begin
          if (flush_i && !last_beat) flush_pend_q <= 1'b1;
          if (mem_ready_i) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == addr_q[OFF_W-1:0]) word_q <= mem_rdata_i;
            if (last_beat) begin
              flush_pend_q <= 1'b0;
              state_q      <= ST_DONE;
            end
          end
        end
        ST_BYPASS: begin
          if (mem_ready_i) begin
            word_q  <= mem_rdata_i;
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/icache_top.sv
module icache_top
  import icache_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 512,
  parameter int unsigned LINE_WORDS = 8,
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
  localparam int unsigned IDX_W     = $clog2(NUM_LINES),
  localparam int unsigned TAG_W     = WADDR_W - IDX_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               flush_i,
  input  logic               fetch_req_i,
  input  logic [WADDR_W-1:0] fetch_addr_i,
  output logic               fetch_valid_o,
  output logic               fetch_hit_o,
  output logic [WORD_W-1:0]  fetch_data_o,
  output logic               stall_o,
  output logic               mem_valid_o,
  output logic [31:0]        mem_addr_o,
  input  logic               mem_ready_i,
  input  logic [WORD_W-1:0]  mem_rdata_i
);
  logic [WADDR_W-1:0] req_addr;
  logic [OFF_W-1:0]   fill_beat;
  logic               data_we, tag_we, flush_all;
  logic [TAG_W-1:0]   rd_tag;
  logic               rd_valid;
  logic               hit;
  logic [WORD_W-1:0]  hit_data;

  wire [IDX_W-1:0] req_idx = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] req_tag = req_addr[WADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] req_off = req_addr[OFF_W-1:0];

  assign hit = rd_valid && (rd_tag == req_tag);

  icache_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (req_idx),
    .rd_tag_o    (rd_tag),
    .rd_valid_o  (rd_valid),
    .wr_en_i     (tag_we),
    .wr_idx_i    (req_idx),
    .wr_tag_i    (req_tag),
    .flush_all_i (flush_all)
  );

  icache_data_store #(.DEPTH(NUM_LINES * LINE_WORDS), .DATA_W(WORD_W)) u_data (
    .clk_i   (clk_i),
    .we_i    (data_we),
    .waddr_i ({req_idx, fill_beat}),
    .wdata_i (mem_rdata_i),
    .raddr_i ({req_idx, req_off}),
    .rdata_o (hit_data)
  );

  icache_fill_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .flush_i       (flush_i),
    .fetch_req_i   (fetch_req_i),
    .fetch_addr_i  (fetch_addr_i),
    .hit_i         (hit),
    .hit_data_i    (hit_data),
    .req_addr_o    (req_addr),
    .fill_beat_o   (fill_beat),
    .data_we_o     (data_we),
    .tag_we_o      (tag_we),
    .flush_all_o   (flush_all),
    .fetch_valid_o (fetch_valid_o),
    .fetch_hit_o   (fetch_hit_o),
    .fetch_data_o  (fetch_data_o),
    .stall_o       (stall_o),
    .mem_valid_o   (mem_valid_o),
    .mem_addr_o    (mem_addr_o),
    .mem_ready_i   (mem_ready_i),
    .mem_rdata_i   (mem_rdata_i)
  );
endmodule

// File: rtl/icache_chk.sv
module icache_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        stall_o,
  input logic        fetch_valid_o,
  input logic        fetch_hit_o,
  input logic        mem_valid_o,
  input logic        mem_ready_i,
  input logic [31:0] mem_addr_o
);
  // R1
  mem_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o));
  // R1
  mem_addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_addr_o[1:0] == 2'b00);
  // R2
  miss_resp_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o && !fetch_hit_o |-> $past(mem_valid_o && mem_ready_i));
  // R3
  hit_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_hit_o |-> fetch_valid_o && !mem_valid_o);
  // R10
  stall_no_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !fetch_valid_o);
endmodule

bind icache_top icache_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stall_o       (stall_o),
  .fetch_valid_o (fetch_valid_o),
  .fetch_hit_o   (fetch_hit_o),
  .mem_valid_o   (mem_valid_o),
  .mem_ready_i   (mem_ready_i),
  .mem_addr_o    (mem_addr_o)
);

// File: tb/tb_icache_top.sv
module tb_icache_top;
  localparam int NL = 512;
  localparam int LW = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic [29:0] fetch_addr_i = '0;
  logic        fetch_valid_o, fetch_hit_o, stall_o, mem_valid_o;
  logic [31:0] fetch_data_o, mem_addr_o;
  logic        mem_ready_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic        mvalid [NL];
  logic [17:0] mtag   [NL];
  logic [31:0] mdata  [NL*LW];
  logic [31:0] patch  [logic [29:0]];
  logic [31:0] logq   [$];

  icache_top dut (.*);

  always #2.5 clk_i = ~clk_i;

  function automatic logic [31:0] mem_read(logic [29:0] wa);
    if (patch.exists(wa)) return patch[wa];
    return ({2'b00, wa} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    mem_ready_i <= rst_ni && ($urandom % 4 != 0);
    mem_rdata_i <= mem_read(mem_addr_o[31:2]);
  end

  always @(posedge clk_i)
    if (rst_ni && mem_valid_o && mem_ready_i) logq.push_back(mem_addr_o);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic model_clear();
    for (int i = 0; i < NL; i++) mvalid[i] = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
    model_clear();
  endtask

  // issues one fetch, compares against the model, updates the model
  task automatic do_fetch(logic [29:0] wa, int flush_after, string req);
    logic [8:0]  idx = wa[11:3];
    logic [17:0] tg  = wa[29:12];
    bit          eh;
    logic [31:0] ed;
    int          waited = 0;
    bit          pulsed = 0;
    eh = mvalid[idx] && (mtag[idx] == tg);
    ed = eh ? mdata[{idx, wa[2:0]}] : mem_read(wa);
    logq.delete();
    @(negedge clk_i); fetch_req_i = 1'b1; fetch_addr_i = wa;
    @(negedge clk_i); fetch_req_i = 1'b0;
    while (!fetch_valid_o && waited < 400) begin
      flush_i = (waited == flush_after);
      if (flush_i) pulsed = 1;
      chk(stall_o, "R10", "stall during miss", {31'd0, stall_o}, 32'd1);
      @(negedge clk_i); waited++;
    end
    flush_i = 1'b0;
    chk(fetch_valid_o, "R10", "response arrives", {31'd0, fetch_valid_o}, 32'd1);
    chk(fetch_data_o == ed, req, "fetch data", fetch_data_o, ed);
    chk(fetch_hit_o == eh, req, "hit flag", {31'd0, fetch_hit_o}, {31'd0, eh});
    if (eh) begin
      chk(waited == 0, "R3", "hit latency", waited, 0);
      chk(logq.size() == 0, "R3", "no reads on hit", logq.size(), 0);
    end else if (enable_i) begin
      chk(logq.size() == LW, "R1", "fill read count", logq.size(), LW);
      for (int k = 0; k < LW && k < logq.size(); k++)
        chk(logq[k] == {wa[29:3], 3'(k), 2'b00}, "R1", "fill order", logq[k],
            {wa[29:3], 3'(k), 2'b00});
      mvalid[idx] = 1'b1;
      mtag[idx]   = tg;
      for (int k = 0; k < LW; k++) mdata[{idx, 3'(k)}] = mem_read({wa[29:3], 3'(k)});
    end else begin
      chk(logq.size() == 1, "R7", "bypass read count", logq.size(), 1);
      if (logq.size() > 0)
        chk(logq[0] == {wa, 2'b00}, "R7", "bypass address", logq[0], {wa, 2'b00});
    end
    if (pulsed) model_clear();
  endtask

  initial begin
    logic [29:0] a, b;
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(!stall_o, "R10", "reset stall", {31'd0, stall_o}, 0);
    chk(!fetch_valid_o, "R10", "reset valid", {31'd0, fetch_valid_o}, 0);
    chk(!mem_valid_o, "R10", "reset mem req", {31'd0, mem_valid_o}, 0);
    rst_ni = 1'b1;
    enable_i = 1'b1;
    repeat (2) @(negedge clk_i);

    a = 30'h0400_0011;                          // byte 0x1000_0044
    do_fetch(a, -1, "R2");                      // miss, fill
    do_fetch(30'h0400_0010, -1, "R3");          // hit same line
    do_fetch(30'h0400_0017, -1, "R3");          // last word of line
    patch[30'h0400_0012] = 32'hDEAD_BEEF;
    do_fetch(30'h0400_0012, -1, "R4");          // stale word returned
    chk(fetch_data_o != 32'hDEAD_BEEF, "R4", "stale not new", fetch_data_o, 32'hDEAD_BEEF);

    b = a | 30'h0000_1000;                      // byte 0x1000_4044, same index
    do_fetch(b, -1, "R9");
    do_fetch(a, -1, "R9");                      // evicted, refill sees patched word
    do_fetch(30'h0400_0012, -1, "R9");
    chk(fetch_data_o == 32'hDEAD_BEEF, "R9", "refill reads memory", fetch_data_o, 32'hDEAD_BEEF);

    @(negedge clk_i); enable_i = 1'b0;
    do_fetch(a, -1, "R8");                      // still hits
    do_fetch(30'h0800_0040, -1, "R7");          // bypass
    do_fetch(30'h0800_0040, -1, "R7");          // misses again
    @(negedge clk_i); enable_i = 1'b1;

    patch[a] = 32'h1234_5678;
    pulse_flush();
    do_fetch(a, -1, "R5");                      // misses after flush
    chk(fetch_data_o == 32'h1234_5678, "R5", "post flush data", fetch_data_o, 32'h1234_5678);

    do_fetch(30'h0C00_0023, 2, "R6");           // flush mid-fill
    do_fetch(30'h0C00_0023, -1, "R6");          // must miss again
    do_fetch(a, -1, "R6");                      // older line also gone

    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 100;
      logic [17:0] t;
      logic [29:0] ra;
      case ($urandom % 3)
        0: t = 18'h00400;
        1: t = 18'h00401;
        default: t = 18'h3ABCD;
      endcase
      ra = {t, 9'(($urandom % 6) * 37), 3'($urandom)};
      if (op < 70) do_fetch(ra, ($urandom % 8 == 0) ? 3 : -1, "R4");
      else if (op < 82) patch[ra] = $urandom;
      else if (op < 88) pulse_flush();
      else begin @(negedge clk_i); enable_i = ($urandom % 3 != 0); end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule